// File: doc/BRIEF.md
# Glitchless Pin-Selected Clock Switcher

The block takes a bank of output channels, each with a first and a second candidate clock, and drives one switched clock per channel. Two shared select pins decide which candidate every channel forwards. A per-channel link field ties each switchable channel to one of the pins, in any grouping. A per-channel lock bit pins a channel to its first clock whatever the pin says. The highest-numbered channels are fixed channels: they have no second candidate and always forward the first clock.

Each switchable channel holds two gating legs, one per candidate clock. A leg samples its request on the rising edges of its own clock through a two-flop synchroniser. It grants or releases on that clock's falling edge, so the gate only moves while its clock is low. A leg asks to run only when its candidate is selected and the opposite leg is seen stopped. The old clock therefore finishes its period and the output rests low. The new clock then enters on its own next rising edge, so no shortened pulse appears at a handover.

Each leg is a two-state machine. In LEG_IDLE the gate is closed, and the GRANT transition moves it to LEG_RUN when the synchronised request is high. In LEG_RUN the gate is open, and the RELEASE transition returns it to LEG_IDLE when the synchronised request is low. Both transitions take effect on a falling edge.

Top module: `glitchless_clk_switch`

## Requirements
- R1: While reset is held and after it is released with select low, every channel forwards its first clock; the first leg starts in LEG_RUN and the second in LEG_IDLE.
- R2: For a switchable channel, an effective select of 0 forwards the first clock and 1 forwards the second once the synchroniser latency has passed; the effective select is the level of the pin named by the channel's link field.
- R3: Link field bit i of `pin_link` equal to 0 ties channel i to `sel_pin[0]` and 1 ties it to `sel_pin[1]`; channels tied to different pins switch independently.
- R4: No high or low phase of any output is shorter than the shorter half-period of that channel's two candidate clocks, including across a handover.
- R5: At a handover the old clock completes its current high phase, the output stays low in the gap, and the new clock's first pulse is a full high phase that starts on the new clock's own rising edge.
- R6: At most one leg of a channel is in LEG_RUN at any time.
- R7: Channels numbered NSEL and above ignore both select pins and always forward their first clock.
- R8: Lock bit i of `lock_first` set to 1 forces channel i to its first clock regardless of the select pin and link field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all legs |
| clk_f1 | input | NCH | First candidate clock of each channel |
| clk_f2 | input | NSEL | Second candidate clock of each switchable channel |
| sel_pin | input | NPIN | Shared frequency-select pins, asynchronous to every clock |
| pin_link | input | NSEL*LINK_W | Per-channel field naming the select pin that steers it |
| lock_first | input | NSEL | Per-channel lock that holds the channel on its first clock |
| clk_out | output | NCH | Switched output clock of each channel |

## Verification
The assertions assume that each effective select, derived from the pins, link fields and lock bits, holds steady long enough for a handover to finish in both clock domains. A reversal while the opposite leg's synchroniser still carries a stale view could open both gates. The stimulus waits many periods of the slowest candidate clock after every change of pins, links or locks before it changes anything again. All changes fall half a nanosecond away from every clock edge, so no sample races an input update. The candidate clocks of each channel run at distinct, unrelated half-periods, so a period measured on an output shows which candidate reached it.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    // State of one gating leg: closed gate or open gate.
    typedef enum logic {
        LEG_IDLE = 1'b0,
        LEG_RUN  = 1'b1
    } leg_state_t;

endpackage

// File: rtl/clksw_selmap.sv
// Fans the shared select pins out to the switchable channels through the
// per-channel link field, then applies the per-channel lock.
module clksw_selmap #(
    parameter int NSEL   = 6,
    parameter int NPIN   = 2,
    parameter int LINK_W = 1
) (
    input  logic [NPIN-1:0]        sel_pin,
    input  logic [NSEL*LINK_W-1:0] pin_link,
    input  logic [NSEL-1:0]        lock_first,
    output logic [NSEL-1:0]        want_f2
);

    for (genvar i = 0; i < NSEL; i++) begin : g_map
        logic [LINK_W-1:0] pin_idx;
        assign pin_idx    = pin_link[i*LINK_W +: LINK_W];
        assign want_f2[i] = ~lock_first[i] & sel_pin[pin_idx];
    end

endmodule

// File: rtl/clksw_leg.sv
// One gating leg: the request is synchronised on rising edges of the leg's
// own clock, and the gate state moves only on its falling edges.
module clksw_leg
    import clksw_pkg::*;
#(
    parameter bit START_ON    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic want,
    input  logic peer_on,
    output logic run,
    output logic gated
);

    localparam int         TOP         = SYNC_STAGES - 1;
    localparam leg_state_t RESET_STATE = START_ON ? LEG_RUN : LEG_IDLE;

    logic                   req;
    logic [SYNC_STAGES-1:0] sync_q;
    leg_state_t             state_q;
    leg_state_t             state_d;

    // Run only if selected and the opposite leg is not running.
    assign req = want & ~peer_on;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{START_ON}};
        end else begin
            sync_q <= {sync_q[TOP-1:0], req};
        end
    end

    // State register, clocked while the clock is low.
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: GRANT (IDLE -> RUN) and RELEASE (RUN -> IDLE).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_IDLE: if (sync_q[TOP])  state_d = LEG_RUN;
            LEG_RUN:  if (!sync_q[TOP]) state_d = LEG_IDLE;
            default:  state_d = LEG_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        run   = (state_q == LEG_RUN);
        gated = clk_in & run;
    end

endmodule

// File: rtl/clksw_chan.sv
// One switchable channel: two cross-coupled legs merged onto one output.
module clksw_chan #(
    parameter int SYNC_STAGES = 2
) (
    input  logic rst_n,
    input  logic clk_f1,
    input  logic clk_f2,
    input  logic want_f2,
    output logic run_f1,
    output logic run_f2,
    output logic clk_out
);

    logic gated_f1;
    logic gated_f2;

    clksw_leg #(
        .START_ON    (1'b1),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_leg_f1 (
        .clk_in  (clk_f1),
        .rst_n   (rst_n),
        .want    (~want_f2),
        .peer_on (run_f2),
        .run     (run_f1),
        .gated   (gated_f1)
    );

    clksw_leg #(
        .START_ON    (1'b0),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_leg_f2 (
        .clk_in  (clk_f2),
        .rst_n   (rst_n),
        .want    (want_f2),
        .peer_on (run_f1),
        .run     (run_f2),
        .gated   (gated_f2)
    );

    assign clk_out = gated_f1 | gated_f2;

endmodule

// File: rtl/glitchless_clk_switch.sv
// Bank of NCH output clocks; the first NSEL channels can switch between two
// candidates, the rest forward their first clock directly.
module glitchless_clk_switch #(
    parameter  int NCH         = 8,
    parameter  int NSEL        = 6,
    parameter  int NPIN        = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int LINK_W      = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic                   rst_n,
    input  logic [NCH-1:0]         clk_f1,
    input  logic [NSEL-1:0]        clk_f2,
    input  logic [NPIN-1:0]        sel_pin,
    input  logic [NSEL*LINK_W-1:0] pin_link,
    input  logic [NSEL-1:0]        lock_first,
    output logic [NCH-1:0]         clk_out
);

    logic [NSEL-1:0] want_f2;
    logic [NSEL-1:0] run_f1;
    logic [NSEL-1:0] run_f2;

    clksw_selmap #(
        .NSEL   (NSEL),
        .NPIN   (NPIN),
        .LINK_W (LINK_W)
    ) u_selmap (
        .sel_pin    (sel_pin),
        .pin_link   (pin_link),
        .lock_first (lock_first),
        .want_f2    (want_f2)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i < NSEL) begin : g_switch
            clksw_chan #(
                .SYNC_STAGES (SYNC_STAGES)
            ) u_chan (
                .rst_n   (rst_n),
                .clk_f1  (clk_f1[i]),
                .clk_f2  (clk_f2[i]),
                .want_f2 (want_f2[i]),
                .run_f1  (run_f1[i]),
                .run_f2  (run_f2[i]),
                .clk_out (clk_out[i])
            );
        end else begin : g_fixed
            assign clk_out[i] = clk_f1[i];
        end
    end

endmodule

// File: rtl/clksw_chk.sv
// Property checker for the switcher, attached by bind below.
module clksw_chk #(
    parameter int NSEL = 6
) (
    input logic            rst_n,
    input logic [NSEL-1:0] clk_f1,
    input logic [NSEL-1:0] clk_f2,
    input logic [NSEL-1:0] want_f2,
    input logic [NSEL-1:0] lock_first,
    input logic [NSEL-1:0] run_f1,
    input logic [NSEL-1:0] run_f2
);

    // Number of edges after reset before the history windows below are valid.
    localparam logic [2:0] AGE_OK = 3'd3;

    for (genvar i = 0; i < NSEL; i++) begin : g_chk
        logic [2:0] age_a;
        logic [2:0] age_b;

        always_ff @(posedge clk_f1[i] or negedge rst_n) begin
            if (!rst_n)                age_a <= 3'd0;
            else if (age_a != 3'd7)    age_a <= age_a + 3'd1;
        end

        always_ff @(posedge clk_f2[i] or negedge rst_n) begin
            if (!rst_n)                age_b <= 3'd0;
            else if (age_b != 3'd7)    age_b <= age_b + 3'd1;
        end

        // R6: the two legs of a channel never run together.
        assert_legs_exclusive_R6: assert property (
            @(posedge clk_f1[i]) disable iff (!rst_n)
            !(run_f1[i] && run_f2[i]));

        // R2: a low effective select held over the window stops the second leg.
        assert_second_off_R2: assert property (
            @(posedge clk_f2[i]) disable iff (!rst_n)
            (age_b >= AGE_OK && !want_f2[i] && !$past(want_f2[i])
             && !$past(want_f2[i], 2) && !$past(want_f2[i], 3))
            |-> !run_f2[i]);

        // R2: a high effective select held over the window stops the first leg.
        assert_first_off_R2: assert property (
            @(posedge clk_f1[i]) disable iff (!rst_n)
            (age_a >= AGE_OK && want_f2[i] && $past(want_f2[i])
             && $past(want_f2[i], 2) && $past(want_f2[i], 3))
            |-> !run_f1[i]);

        // R8: a held lock keeps the second leg stopped.
        assert_lock_first_R8: assert property (
            @(posedge clk_f2[i]) disable iff (!rst_n)
            (age_b >= AGE_OK && lock_first[i] && $past(lock_first[i])
             && $past(lock_first[i], 2) && $past(lock_first[i], 3))
            |-> !run_f2[i]);
    end

endmodule

bind glitchless_clk_switch clksw_chk #(
    .NSEL (NSEL)
) u_clksw_chk (
    .rst_n      (rst_n),
    .clk_f1     (clk_f1[NSEL-1:0]),
    .clk_f2     (clk_f2),
    .want_f2    (want_f2),
    .lock_first (lock_first),
    .run_f1     (run_f1),
    .run_f2     (run_f2)
);

// File: tb/glitchless_clk_switch_test.sv
`timescale 1ns/100ps
module glitchless_clk_switch_test;

    localparam int NCH       = 8;
    localparam int NSEL      = 6;
    localparam int NPIN      = 2;
    localparam int LINK_W    = 1;
    localparam int CLK_NS    = 10;
    localparam int SETTLE_NS = 60 * CLK_NS;

    // Half-period of each candidate clock; second candidates are always slower.
    function automatic int half_of(int ch, bit second);
        return second ? (CLK_NS + 2 * ch + 3) : (CLK_NS / 2 + ch);
    endfunction

    wire  [NCH-1:0]         clk_f1;
    wire  [NSEL-1:0]        clk_f2;
    wire  [NCH-1:0]         clk_out;
    logic                   rst_n;
    logic [NPIN-1:0]        sel_pin;
    logic [NSEL*LINK_W-1:0] pin_link;
    logic [NSEL-1:0]        lock_first;

    int checks   = 0;
    int fails    = 0;
    int runt_cnt = 0;
    bit done     = 0;
    bit mon_busy = 0;
    int period_ns [NCH];
    int rise_cnt  [NCH];

    typedef struct {
        int    ch;
        int    period;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    glitchless_clk_switch #(
        .NCH  (NCH),
        .NSEL (NSEL),
        .NPIN (NPIN)
    ) uut (
        .rst_n      (rst_n),
        .clk_f1     (clk_f1),
        .clk_f2     (clk_f2),
        .sel_pin    (sel_pin),
        .pin_link   (pin_link),
        .lock_first (lock_first),
        .clk_out    (clk_out)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ck1
        logic ck = 1'b0;
        initial forever #(half_of(g, 1'b0)) ck = ~ck;
        assign clk_f1[g] = ck;
    end

    for (genvar g = 0; g < NSEL; g++) begin : g_ck2
        logic ck = 1'b0;
        initial forever #(half_of(g, 1'b1)) ck = ~ck;
        assign clk_f2[g] = ck;
    end

    // Per-channel phase monitor: runt detection and period capture.
    for (genvar g = 0; g < NCH; g++) begin : g_mon
        real last_edge = 0.0;
        real last_rise = 0.0;
        bit  have_edge = 0;
        bit  have_rise = 0;
        initial begin
            period_ns[g] = 0;
            rise_cnt[g]  = 0;
        end
        always @(clk_out[g]) begin
            if (!rst_n) begin
                have_edge = 0;
                have_rise = 0;
            end else begin
                if (have_edge && (($realtime - last_edge) < real'(half_of(g, 1'b0)))) begin
                    runt_cnt++;
                    $display("runt phase on ch%0d at %0t: %0.1f ns", g, $time,
                             $realtime - last_edge);
                end
                last_edge = $realtime;
                have_edge = 1;
                if (clk_out[g] === 1'b1) begin
                    if (have_rise) period_ns[g] = int'($realtime - last_rise);
                    last_rise = $realtime;
                    have_rise = 1;
                    rise_cnt[g]++;
                end
            end
        end
    end

    // Scoreboard monitor: pops an expectation and compares a fresh period.
    initial begin
        forever begin
            exp_t item;
            int   c0;
            while (sb_q.size() == 0) #1;
            mon_busy = 1;
            item = sb_q.pop_front();
            c0   = rise_cnt[item.ch];
            while (rise_cnt[item.ch] < c0 + 2) #1;
            checks++;
            if (period_ns[item.ch] != item.period) begin
                fails++;
                $display("FAIL %s ch%0d period actual=%0d expected=%0d",
                         item.tag, item.ch, period_ns[item.ch], item.period);
            end
            mon_busy = 0;
        end
    end

    // Expected effective select, from R2, R3, R7 and R8.
    function automatic bit exp_second(int ch);
        if (ch >= NSEL)     return 1'b0;
        if (lock_first[ch]) return 1'b0;
        return sel_pin[pin_link[ch*LINK_W +: LINK_W]];
    endfunction

    task automatic push_all(string tag);
        for (int ch = 0; ch < NCH; ch++) begin
            exp_t  e;
            string t;
            if (ch >= NSEL)          t = "R7";
            else if (lock_first[ch]) t = "R8";
            else                     t = tag;
            e.ch     = ch;
            e.period = 2 * half_of(ch, exp_second(ch));
            e.tag    = t;
            sb_q.push_back(e);
        end
        while (sb_q.size() != 0 || mon_busy) #1;
    endtask

    task automatic apply(logic [NPIN-1:0] s, logic [NSEL-1:0] lk,
                         logic [NSEL-1:0] lock, string tag);
        sel_pin    = s;
        pin_link   = lk;
        lock_first = lock;
        #(SETTLE_NS);
        push_all(tag);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        sel_pin    = '0;
        pin_link   = 6'b111000;
        lock_first = '0;
        #100.5;
        rst_n = 1'b1;
        #(SETTLE_NS);
        push_all("R1");                                   // reset state
        apply(2'b01, 6'b111000, 6'b000000, "R2");         // pin0 high
        apply(2'b10, 6'b111000, 6'b000000, "R3");         // pin1 high only
        apply(2'b11, 6'b111000, 6'b000010, "R2");         // ch1 locked
        apply(2'b01, 6'b010101, 6'b000000, "R3");         // interleaved links
        apply(2'b10, 6'b010101, 6'b000000, "R3");
        apply(2'b00, 6'b010101, 6'b000000, "R2");         // back to first
        checks++;
        if (runt_cnt != 0) begin
            fails++;
            $display("FAIL R4/R5/R6 short phases actual=%0d expected=0", runt_cnt);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule